// File: doc/BRIEF.md
# PLL Scan-Chain Reconfiguration Controller

This controller rewrites the counter settings of a phase-locked loop through the loop's serial scan chain. A host presents a full configuration image in parallel, says whether that image touches the loop-critical settings, and pulses a start request. The controller then runs the whole serial handshake by itself. It raises the scan enable one cycle early and streams the image into the chain, most significant bit first. It drops the enable and issues a single-cycle update strobe. It then follows the PLL's done signal through its rise and its fall and, when required, holds the PLL in reset for a fixed number of cycles.

The controller runs on the scan clock. The chain length is a parameter, 180 bits by default and 234 for the longer chains. A timeout guards both edges of the done handshake, and when it expires the run ends with an error pulse instead of a completion pulse. Once the controller is idle again, the host may start another run, as many times as it likes.

Top module: `pll_scan_cfg`

## Requirements
- R1: While reset is asserted, and after its release until a start is accepted, scan_ena_o, scan_data_o, cfg_update_o, pll_reset_o, busy_o, complete_o and error_o are all 0.
- R2: For each accepted start, scan_ena_o is high for exactly CHAIN_LEN+1 consecutive cycles. The first of these cycles carries no data, so the enable leads the first data bit by one scan-clock cycle.
- R3: A chain that shifts on every rising edge where the enable was already high on the previous edge receives image_i in the order bit CHAIN_LEN-1 down to bit 0. After the run it holds image_i exactly, and it has pushed out its previous contents.
- R4: cfg_update_o is high for exactly one cycle per run, in the cycle directly after the last enable cycle, and never while scan_ena_o is high.
- R5: complete_o is raised only after scan_done_i has risen and then fallen.
- R6: When img_changes_loop_i was 1 at the accepted start, pll_reset_o is high for exactly RST_CYCLES consecutive cycles between the done fall and complete_o. When it was 0, pll_reset_o stays low.
- R7: complete_o is a one-cycle pulse, and busy_o is high from the cycle after an accepted start through the complete or error cycle and low in the cycle after it.
- R8: A start request while busy_o is high is ignored: the running image, its flag and its single update strobe are unaffected, and no further run follows.
- R9: If scan_done_i has not risen within TIMEOUT cycles after the update strobe, error_o pulses for one cycle in the TIMEOUT+1-th cycle after the strobe. No complete or PLL reset is issued, and busy_o then drops.
- R10: If scan_done_i has not fallen within TIMEOUT cycles after rising, error_o pulses and the run ends without complete or PLL reset.
- R11: After a completed or failed run, a new start performs a full, correct sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| image_i | input | CHAIN_LEN | Configuration image, bit CHAIN_LEN-1 sent first |
| img_changes_loop_i | input | 1 | Image changes loop-critical settings, so a PLL reset is needed |
| scan_done_i | input | 1 | Done handshake from the PLL |
| scan_ena_o | output | 1 | Scan clock enable |
| scan_data_o | output | 1 | Serial scan data |
| cfg_update_o | output | 1 | One-cycle configuration-update strobe |
| pll_reset_o | output | 1 | PLL reset pulse |
| busy_o | output | 1 | Sequence in progress |
| complete_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds the controller with CHAIN_LEN set to 234, RST_CYCLES to 3 and TIMEOUT to 20. The long-chain variant is exercised end to end against a behavioural chain that holds off its first shift by one edge. The short timeout makes both done-timeout paths reachable in a few dozen cycles, and the exact error cycle after a missing rise can be checked against that value. Because the reset length is three cycles, an off-by-one in the reset window shows up directly as a wrong pulse count.

// File: rtl/pll_scan_pkg.sv
package pll_scan_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_UPDATE,
    ST_WRISE,
    ST_WFALL,
    ST_PRST,
    ST_FINISH,
    ST_FAIL
  } scan_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pll_scan_shreg.sv
module pll_scan_shreg #(
  parameter int unsigned LEN = 180
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [LEN-1:0] image_i,
  input  logic           shift_i,
  output logic           bit_o
);

  logic [LEN-1:0] q_r;
  logic [LEN-1:0] q_nx;
  logic           q_en;

  always_comb begin
    q_en = load_i | shift_i;
    q_nx = q_r;
    if (load_i) begin
      q_nx = image_i;
    end else if (shift_i) begin
      q_nx = {q_r[LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (q_en) begin
      q_r <= q_nx;
    end
  end

  assign bit_o = q_r[LEN-1];

endmodule

// File: rtl/pll_scan_timer.sv
module pll_scan_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nx;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_nx = clr_i ? '0 : cnt_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
    end else if (cnt_en) begin
      cnt_r <= cnt_nx;
    end
  end

  assign cnt_o = cnt_r;

endmodule

// File: rtl/pll_scan_fsm.sv
module pll_scan_fsm
  import pll_scan_pkg::*;
#(
  parameter int unsigned LEN   = 180,
  parameter int unsigned RSTC  = 4,
  parameter int unsigned TMO   = 64,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             chg_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] cnt_i,
  output scan_state_t      state_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(LEN - 1);
  localparam logic [CNT_W-1:0] LAST_TMO = CNT_W'(TMO - 1);
  localparam logic [CNT_W-1:0] LAST_RST = CNT_W'(RSTC - 1);

  scan_state_t st_r;
  scan_state_t st_nx;
  logic        chg_r;

  always_comb begin
    st_nx     = st_r;
    load_o    = 1'b0;
    shift_o   = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (st_r)
      ST_IDLE: begin
        if (start_i) begin
          st_nx     = ST_LEAD;
          load_o    = 1'b1;
          cnt_clr_o = 1'b1;
        end
      end
      ST_LEAD: begin
        st_nx     = ST_SHIFT;
        cnt_clr_o = 1'b1;
      end
      ST_SHIFT: begin
        shift_o = 1'b1;
        if (cnt_i == LAST_BIT) st_nx = ST_UPDATE;
        else                   cnt_inc_o = 1'b1;
      end
      ST_UPDATE: begin
        st_nx     = ST_WRISE;
        cnt_clr_o = 1'b1;
      end
      ST_WRISE: begin
        if (done_i) begin
          st_nx     = ST_WFALL;
          cnt_clr_o = 1'b1;
        end else if (cnt_i == LAST_TMO) begin
          st_nx = ST_FAIL;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      ST_WFALL: begin
        if (!done_i) begin
          st_nx     = chg_r ? ST_PRST : ST_FINISH;
          cnt_clr_o = 1'b1;
        end else if (cnt_i == LAST_TMO) begin
          st_nx = ST_FAIL;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      ST_PRST: begin
        if (cnt_i == LAST_RST) st_nx = ST_FINISH;
        else                   cnt_inc_o = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r  <= ST_IDLE;
      chg_r <= 1'b0;
    end else begin
      st_r <= st_nx;
      if (load_o) chg_r <= chg_i;
    end
  end

  assign state_o = st_r;

endmodule

// File: rtl/pll_scan_cfg.sv
module pll_scan_cfg
  import pll_scan_pkg::*;
#(
  parameter int unsigned CHAIN_LEN  = 180,
  parameter int unsigned RST_CYCLES = 4,
  parameter int unsigned TIMEOUT    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CHAIN_LEN-1:0] image_i,
  input  logic                 img_changes_loop_i,
  input  logic                 scan_done_i,
  output logic                 scan_ena_o,
  output logic                 scan_data_o,
  output logic                 cfg_update_o,
  output logic                 pll_reset_o,
  output logic                 busy_o,
  output logic                 complete_o,
  output logic                 error_o
);

  localparam int unsigned CNT_MAX = max3(CHAIN_LEN, RST_CYCLES, TIMEOUT);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0]       rst_sync_r;
  logic             rst_int_n;
  scan_state_t      state;
  logic             load;
  logic             shift;
  logic             cnt_clr;
  logic             cnt_inc;
  logic [CNT_W-1:0] cnt;
  logic             sh_bit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_r <= 2'b00;
    else        rst_sync_r <= {rst_sync_r[0], 1'b1};
  end
  assign rst_int_n = rst_sync_r[1];

  pll_scan_fsm #(
    .LEN  (CHAIN_LEN),
    .RSTC (RST_CYCLES),
    .TMO  (TIMEOUT),
    .CNT_W(CNT_W)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .chg_i    (img_changes_loop_i),
    .done_i   (scan_done_i),
    .cnt_i    (cnt),
    .state_o  (state),
    .load_o   (load),
    .shift_o  (shift),
    .cnt_clr_o(cnt_clr),
    .cnt_inc_o(cnt_inc)
  );

  pll_scan_timer #(.W(CNT_W)) i_timer (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr_i(cnt_clr),
    .inc_i(cnt_inc),
    .cnt_o(cnt)
  );

  pll_scan_shreg #(.LEN(CHAIN_LEN)) i_shreg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .image_i(image_i),
    .shift_i(shift),
    .bit_o  (sh_bit)
  );

  always_comb begin
    scan_ena_o   = (state == ST_LEAD) || (state == ST_SHIFT);
    scan_data_o  = (state == ST_SHIFT) & sh_bit;
    cfg_update_o = (state == ST_UPDATE);
    pll_reset_o  = (state == ST_PRST);
    busy_o       = (state != ST_IDLE);
    complete_o   = (state == ST_FINISH);
    error_o      = (state == ST_FAIL);
  end

endmodule

// File: rtl/pll_scan_cfg_chk.sv
module pll_scan_cfg_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic scan_ena_o,
  input logic cfg_update_o,
  input logic pll_reset_o,
  input logic busy_o,
  input logic complete_o,
  input logic error_o
);

  AST_ENA_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_ena_o) |=> scan_ena_o); // R2

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update_o |=> !cfg_update_o); // R4

  AST_UPD_NO_ENA: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update_o |-> !scan_ena_o); // R4

  AST_UPD_AFTER_ENA: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update_o |-> $past(scan_ena_o)); // R4

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pll_reset_o |-> (!scan_ena_o && !cfg_update_o && busy_o)); // R6

  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({complete_o, error_o})); // R7

  AST_CMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |=> (!complete_o && !busy_o)); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !complete_o && !error_o) |=> busy_o); // R8

  AST_ERR_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !pll_reset_o); // R9

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> (!error_o && !busy_o)); // R10

  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o); // R11

endmodule

bind pll_scan_cfg pll_scan_cfg_chk i_pll_scan_cfg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .scan_ena_o  (scan_ena_o),
  .cfg_update_o(cfg_update_o),
  .pll_reset_o (pll_reset_o),
  .busy_o      (busy_o),
  .complete_o  (complete_o),
  .error_o     (error_o)
);

// File: tb/test_pll_scan_cfg.sv
module test_pll_scan_cfg;

  localparam int LEN  = 234;
  localparam int RSTC = 3;
  localparam int TMO  = 20;

  // seed[31:24], loop-change flag[16], rise delay[15:8], fall delay[7:0]
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h5A01_0002, 32'h1300_0300, 32'hC701_0506,
    32'h0000_0101, 32'hFF01_0803, 32'h8100_0000
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           start;
  logic [LEN-1:0] image;
  logic           chg;
  logic           done = 1'b0;
  logic           ena, sdata, upd, prst, busy, cmp, err;

  pll_scan_cfg #(.CHAIN_LEN(LEN), .RST_CYCLES(RSTC), .TIMEOUT(TMO)) i_pll_scan_cfg (
    .clk(clk), .rst_n(rst_n), .start_i(start), .image_i(image),
    .img_changes_loop_i(chg), .scan_done_i(done), .scan_ena_o(ena),
    .scan_data_o(sdata), .cfg_update_o(upd), .pll_reset_o(prst),
    .busy_o(busy), .complete_o(cmp), .error_o(err)
  );

  // behavioural scan chain and done handshake
  logic [LEN-1:0] chain  = {(LEN/2){2'b10}};
  logic [LEN-1:0] outcap = '0;
  logic armed = 1'b0;
  int   dphase = 0, dcnt = 0, rise_dly = 0, fall_dly = 0;
  bit   no_rise = 0, no_fall = 0, stub_kill = 0;

  always @(posedge clk) begin
    armed <= ena;
    if (ena && armed) begin
      chain  <= {chain[LEN-2:0], sdata};
      outcap <= {outcap[LEN-2:0], chain[LEN-1]};
    end
    if (stub_kill) begin
      dphase <= 0; done <= 1'b0;
    end else if (upd) begin
      dphase <= 1; dcnt <= 0;
    end else if (dphase == 1) begin
      if (dcnt >= rise_dly && !no_rise) begin done <= 1'b1; dphase <= 2; dcnt <= 0; end
      else dcnt <= dcnt + 1;
    end else if (dphase == 2) begin
      if (dcnt >= fall_dly && !no_fall) begin done <= 1'b0; dphase <= 0; end
      else dcnt <= dcnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [LEN-1:0] act,
                     input logic [LEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LEN-1:0] mkimg(input logic [7:0] s);
    logic [LEN-1:0] r;
    for (int i = 0; i < LEN; i++) r[i] = s[i%8] ^ (((i * 3 + int'(s)) % 7) < 3);
    return r;
  endfunction

  // results of one run
  int ena_cnt, upd_cnt, rst_cnt, err_at, cmp_rst;
  bit upd_bad, fall_seen, got_cmp, got_err, cmp_fall, busy_after;
  logic [LEN-1:0] prev_chain;

  task automatic run(input logic [LEN-1:0] img, input bit c, input int rd, input int fd,
                     input bit nr, input bit nf, input int inj);
    int  since_upd;
    bit  prev_ena, prev_done;
    stub_kill = 1; @(negedge clk); stub_kill = 0;
    rise_dly = rd; fall_dly = fd; no_rise = nr; no_fall = nf;
    prev_chain = chain;
    start = 1'b1; image = img; chg = c;
    @(negedge clk);
    start = 1'b0;
    ena_cnt = 0; upd_cnt = 0; rst_cnt = 0; err_at = -1; cmp_rst = -1;
    upd_bad = 0; fall_seen = 0; got_cmp = 0; got_err = 0; cmp_fall = 0;
    since_upd = -1; prev_ena = 0; prev_done = 0;
    for (int k = 0; k < 2000; k++) begin
      if (ena) ena_cnt++;
      if (upd) begin
        upd_cnt++;
        if (!(prev_ena && !ena)) upd_bad = 1;
        since_upd = 0;
      end else if (since_upd >= 0) begin
        since_upd++;
      end
      if (prst) rst_cnt++;
      if (prev_done && !done) fall_seen = 1;
      if (cmp) begin got_cmp = 1; cmp_fall = fall_seen; cmp_rst = rst_cnt; end
      if (err) begin got_err = 1; err_at = since_upd; end
      prev_ena = ena; prev_done = done;
      if (cmp || err) break;
      if (k == inj) begin start = 1'b1; image = ~img; chg = ~c; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    busy_after = busy;
  endtask

  task automatic check_ok_run(input logic [LEN-1:0] img, input bit c, input string tag);
    chk(ena_cnt == LEN + 1, {"R2 enable cycles ", tag}, ena_cnt, LEN + 1);
    chk(chain == img, {"R3 chain contents ", tag}, chain, img);
    chk(outcap == prev_chain, {"R3 old contents out ", tag}, outcap, prev_chain);
    chk(upd_cnt == 1 && !upd_bad, {"R4 update strobe ", tag}, upd_cnt, 1);
    chk(got_cmp && cmp_fall, {"R5 complete after done fall ", tag}, cmp_fall, 1);
    chk(cmp_rst == (c ? RSTC : 0), {"R6 reset cycles ", tag}, cmp_rst, c ? RSTC : 0);
    chk(!busy_after && !got_err, {"R7 busy drops after complete ", tag}, busy_after, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; image = '0; chg = 1'b0;
    repeat (3) @(negedge clk);
    chk({ena, sdata, upd, prst, busy, cmp, err} == 7'b0, "R1 outputs in reset",
        {ena, sdata, upd, prst, busy, cmp, err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({ena, sdata, upd, prst, busy, cmp, err} == 7'b0, "R1 outputs idle after release",
        {ena, sdata, upd, prst, busy, cmp, err}, 0);

    // table-driven runs
    for (int v = 0; v < NVEC; v++) begin
      logic [LEN-1:0] img;
      img = mkimg(VEC[v][31:24]);
      run(img, VEC[v][16], int'(VEC[v][15:8]), int'(VEC[v][7:0]), 0, 0, -1);
      check_ok_run(img, VEC[v][16], $sformatf("vec %0d", v));
    end

    // R8: start while busy is ignored
    begin
      logic [LEN-1:0] img;
      img = mkimg(8'h3C);
      run(img, 1'b0, 2, 2, 0, 0, 10);
      chk(chain == img, "R8 running image kept", chain, img);
      chk(upd_cnt == 1, "R8 single update strobe", upd_cnt, 1);
      chk(cmp_rst == 0, "R8 flag not overwritten", cmp_rst, 0);
      repeat (4) @(negedge clk);
      chk(!busy && !ena, "R8 no second run", {busy, ena}, 0);
    end

    // R9: done never rises
    run(mkimg(8'h77), 1'b1, 0, 0, 1, 0, -1);
    chk(got_err && !got_cmp, "R9 error without complete", {got_err, got_cmp}, 2'b10);
    chk(err_at == TMO + 1, "R9 error cycle after strobe", err_at, TMO + 1);
    chk(rst_cnt == 0, "R9 no PLL reset", rst_cnt, 0);
    chk(!busy_after, "R9 busy drops", busy_after, 0);

    // R10: done never falls
    run(mkimg(8'h19), 1'b1, 1, 0, 0, 1, -1);
    chk(got_err && !got_cmp, "R10 error without complete", {got_err, got_cmp}, 2'b10);
    chk(rst_cnt == 0, "R10 no PLL reset", rst_cnt, 0);
    chk(!busy_after, "R10 busy drops", busy_after, 0);

    // R11: full run again after a failure
    begin
      logic [LEN-1:0] img;
      img = mkimg(8'hE4);
      run(img, 1'b1, 3, 4, 0, 0, -1);
      chk(chain == img && got_cmp, "R11 run after error", chain, img);
      chk(cmp_rst == RSTC, "R11 reset after error recovery", cmp_rst, RSTC);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule